// File: doc/BRIEF.md
# Mixed-Precision 4x4 Matrix Multiply-Accumulate Unit

This block evaluates D = A x B + C on square matrices of side four. A and B hold IEEE-754 half-precision values. C and D are each chosen as half or single precision for every operation. Every product of two half-precision values is formed exactly in single precision and added into a single-precision running sum. When a half-precision result is requested, that sum is narrowed only at the moment it is stored.

A host fills the operand banks one element per cycle through a write port. It then pulses a start input and waits for a one-cycle done pulse. After that it reads the result matrix one element per cycle by index.

A single shared multiply-add datapath does the work: one multiply-accumulate step per cycle, 64 steps in all. The controller is a three-state machine. IDLE waits for start. RUN issues steps 0 to 63 and leaves on the last step. DONE lasts one cycle and returns to IDLE. Its transitions are: IDLE to RUN on start, RUN to RUN while steps remain, RUN to DONE on step 63, and DONE to IDLE unconditionally.

Top module: `mmac4_unit`

## Requirements
- R1: After reset, busy and done are 0 and every result element reads back as 0.
- R2: With wr_en high, wr_sel 0 writes wr_data[15:0] into A, 1 writes into B and 2 writes into C, at element wr_idx = row*4+col. C uses all 32 bits when the operation selects single-precision C, and bits [15:0] otherwise.
- R3: A start captured in IDLE makes busy high from the next edge. done is high for exactly one cycle, following the 64th edge after the capturing edge. busy is low again one edge later.
- R4: A start arriving while busy is ignored: done timing and the results are those of the operation already running.
- R5: Element (r,c) is computed as c + a(r,0)b(0,c) + a(r,1)b(1,c) + a(r,2)b(2,c) + a(r,3)b(3,c), added in that order. Each product is exact, and each addition is rounded to single precision, round-to-nearest-even.
- R6: A half-precision C element is widened exactly to single precision before the first addition.
- R7: With half-precision output, the single-precision sum is rounded to nearest-even. Values that round beyond 65504 give signed infinity, and magnitudes below 2^-14 give signed zero.
- R8: Subnormal half-precision inputs and subnormal single-precision operands are treated as signed zero. A sum below the single-precision normal range is flushed to signed zero.
- R9: Any NaN operand, infinity times zero, or the sum of opposite infinities yields the canonical quiet NaN: 0x7FC00000 for single-precision output, 0x7E00 for half-precision output. Infinities propagate with their sign.
- R10: rd_data shows result element rd_idx. A half-precision result occupies bits [15:0] with bits [31:16] zero. Results stay unchanged while the unit is idle.
- R11: c_wide (1 = single-precision C) and d_wide (1 = single-precision D) are sampled only with an accepted start and hold for the whole operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Operand write strobe |
| wr_sel | input | 2 | Operand bank: 0 A, 1 B, 2 C |
| wr_idx | input | 4 | Element index row*4+col |
| wr_data | input | 32 | Operand value |
| c_wide | input | 1 | C is single precision when 1 |
| d_wide | input | 1 | D is single precision when 1 |
| start | input | 1 | Begin an operation (idle only) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_idx | input | 4 | Result element index |
| rd_data | output | 32 | Result element value |

## Verification
The embedded properties check on every cycle that done is a single-cycle pulse reached only from the last step, that a start during RUN neither restarts nor stalls the step count, and that the latched precision modes stay fixed through an operation. They also check that a flushed subnormal operand yields a zero product, that every NaN leaving the adder is canonical, and that narrowed results are zero-extended. Only the bench scenarios can show the numeric outcomes. These include the exact integer results of whole matrices in all four precision pairings, and ties that resolve to even in both the running sum and the final narrowing. They also include overflow to infinity, invalid-operation NaNs, and the effect of the fixed addition order on a large accumulator.

// File: rtl/mmac4_pkg.sv
package mmac4_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} mac_state_e;

    localparam logic [31:0] SP_QNAN = 32'h7FC0_0000;
    localparam logic [15:0] HP_QNAN = 16'h7E00;

    // exact widening, subnormals flushed
    function automatic logic [31:0] h2s(input logic [15:0] h);
        logic [31:0] r;
        if (h[14:10] == 5'd0)
            r = {h[15], 31'd0};
        else if (h[14:10] == 5'h1F)
            r = (h[9:0] != 10'd0) ? SP_QNAN : {h[15], 8'hFF, 23'd0};
        else
            r = {h[15], 3'b000, h[14:10] + 5'd0, h[9:0], 13'd0} + {1'b0, 8'd112, 23'd0};
        return r;
    endfunction

    // exact half x half product in single precision
    function automatic logic [31:0] hmul(input logic [15:0] a, input logic [15:0] b);
        logic        s, na, nb, ia, ib, za, zb;
        logic [21:0] m;
        logic [7:0]  e;
        logic [31:0] r;
        s  = a[15] ^ b[15];
        na = (a[14:10] == 5'h1F) && (a[9:0] != 10'd0);
        nb = (b[14:10] == 5'h1F) && (b[9:0] != 10'd0);
        ia = (a[14:10] == 5'h1F) && (a[9:0] == 10'd0);
        ib = (b[14:10] == 5'h1F) && (b[9:0] == 10'd0);
        za = (a[14:10] == 5'd0);
        zb = (b[14:10] == 5'd0);
        m  = {1'b1, a[9:0]} * {1'b1, b[9:0]};
        e  = {3'd0, a[14:10]} + {3'd0, b[14:10]} + 8'd97;
        if (na || nb || (ia && zb) || (ib && za))
            r = SP_QNAN;
        else if (ia || ib)
            r = {s, 8'hFF, 23'd0};
        else if (za || zb)
            r = {s, 31'd0};
        else if (m[21])
            r = {s, e + 8'd1, m[20:0], 2'b00};
        else
            r = {s, e, m[19:0], 3'b000};
        return r;
    endfunction

    // single-precision add, nearest-even, flush-to-zero
    function automatic logic [31:0] sadd(input logic [31:0] p, input logic [31:0] q);
        logic        xs, ys, np, nq, ip, iq, zp, zq, st, up;
        logic [7:0]  xe, ye, d, eb;
        logic [22:0] xf, yf;
        logic [26:0] mx, my, sh;
        logic [27:0] sm;
        logic [24:0] rm;
        int          e;
        logic [31:0] r;
        np = (p[30:23] == 8'hFF) && (p[22:0] != 23'd0);
        nq = (q[30:23] == 8'hFF) && (q[22:0] != 23'd0);
        ip = (p[30:23] == 8'hFF) && (p[22:0] == 23'd0);
        iq = (q[30:23] == 8'hFF) && (q[22:0] == 23'd0);
        zp = (p[30:23] == 8'd0);
        zq = (q[30:23] == 8'd0);
        r  = 32'd0;
        if (np || nq)            r = SP_QNAN;
        else if (ip && iq)       r = (p[31] != q[31]) ? SP_QNAN : p;
        else if (ip)             r = p;
        else if (iq)             r = q;
        else if (zp && zq)       r = {p[31] & q[31], 31'd0};
        else if (zp)             r = q;
        else if (zq)             r = p;
        else begin
            if (p[30:0] >= q[30:0]) begin
                {xs, xe, xf} = p; {ys, ye, yf} = q;
            end else begin
                {xs, xe, xf} = q; {ys, ye, yf} = p;
            end
            mx = {1'b1, xf, 3'b000};
            my = {1'b1, yf, 3'b000};
            d  = xe - ye;
            st = 1'b0;
            for (int i = 0; i < 27; i++)
                if ((i < int'(d)) && my[i]) st = 1'b1;
            sh = (d > 8'd26) ? 27'd0 : (my >> d);
            sh = {sh[26:1], sh[0] | st};
            sm = (xs != ys) ? ({1'b0, mx} - {1'b0, sh}) : ({1'b0, mx} + {1'b0, sh});
            e  = int'(xe);
            if (sm == 28'd0) begin
                r = 32'd0;
            end else begin
                if (sm[27]) begin
                    sm = {1'b0, sm[27:2], sm[1] | sm[0]};
                    e  = e + 1;
                end else begin
                    for (int i = 0; i < 26; i++)
                        if (!sm[26]) begin
                            sm = sm << 1;
                            e  = e - 1;
                        end
                end
                up = sm[2] && (sm[1] || sm[0] || sm[3]);
                rm = {1'b0, sm[26:3]} + {24'd0, up};
                if (rm[24]) begin
                    rm = {1'b0, rm[24:1]};
                    e  = e + 1;
                end
                eb = 8'(e);
                if (e >= 255)    r = {xs, 8'hFF, 23'd0};
                else if (e <= 0) r = {xs, 31'd0};
                else             r = {xs, eb, rm[22:0]};
            end
        end
        return r;
    endfunction

    // single to half, nearest-even
    function automatic logic [15:0] s2h(input logic [31:0] v);
        logic [10:0] mt;
        logic        up;
        int          h;
        logic [15:0] r;
        h  = int'(v[30:23]) - 112;
        up = v[12] && ((v[11:0] != 12'd0) || v[13]);
        mt = {1'b0, v[22:13]} + {10'd0, up};
        if (mt[10]) h = h + 1;
        if (v[30:23] == 8'hFF)
            r = (v[22:0] != 23'd0) ? HP_QNAN : {v[31], 15'h7C00};
        else if (v[30:23] == 8'd0 || int'(v[30:23]) - 112 <= 0)
            r = {v[31], 15'd0};
        else if (h >= 31)
            r = {v[31], 15'h7C00};
        else
            r = {v[31], 5'(h), mt[9:0]};
        return r;
    endfunction

endpackage

// File: rtl/mmac4_opstore.sv
module mmac4_opstore
    import mmac4_pkg::*;
#(
    parameter int DIM = 4,
    parameter int EW  = 2 * $clog2(DIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [EW-1:0] wr_idx,
    input  logic [31:0]   wr_data,
    input  logic [EW-1:0] a_idx,
    input  logic [EW-1:0] b_idx,
    input  logic [EW-1:0] c_idx,
    output logic [15:0]   a_q,
    output logic [15:0]   b_q,
    output logic [31:0]   c_q
);
    localparam int NEL = DIM * DIM;

    logic [15:0] a_mem [NEL];
    logic [15:0] b_mem [NEL];
    logic [31:0] c_mem [NEL];

    for (genvar g = 0; g < NEL; g++) begin : g_el
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                a_mem[g] <= '0;
                b_mem[g] <= '0;
                c_mem[g] <= '0;
            end else if (wr_en && wr_idx == EW'(g)) begin
                if (wr_sel == 2'd0) a_mem[g] <= wr_data[15:0];
                if (wr_sel == 2'd1) b_mem[g] <= wr_data[15:0];
                if (wr_sel == 2'd2) c_mem[g] <= wr_data;
            end
        end
    end

    assign a_q = a_mem[a_idx];
    assign b_q = b_mem[b_idx];
    assign c_q = c_mem[c_idx];
endmodule

// File: rtl/mmac4_step.sv
module mmac4_step
    import mmac4_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        first,
    input  logic        c_wide,
    input  logic [31:0] acc_q,
    input  logic [31:0] c_raw,
    input  logic [15:0] a_op,
    input  logic [15:0] b_op,
    output logic [31:0] sum
);
    logic [31:0] acc_in;
    logic [31:0] prod;

    always_comb begin
        if (first) acc_in = c_wide ? c_raw : h2s(c_raw[15:0]);
        else       acc_in = acc_q;
        prod = hmul(a_op, b_op);
        sum  = sadd(acc_in, prod);
    end

    // R8: a subnormal half input gives a zero product unless the other is special
    p_ftz_prod_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (a_op[14:10] == 5'd0 && b_op[14:10] != 5'h1F) |-> prod[30:0] == 31'd0);

    // R9: the adder only ever emits the canonical NaN
    p_nan_canon_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sum[30:23] == 8'hFF && sum[22:0] != 23'd0) |-> sum == SP_QNAN);
endmodule

// File: rtl/mmac4_rstore.sv
module mmac4_rstore
    import mmac4_pkg::*;
#(
    parameter int DIM = 4,
    parameter int EW  = 2 * $clog2(DIM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wb_en,
    input  logic [EW-1:0] wb_idx,
    input  logic [31:0]   wb_val,
    input  logic          d_wide,
    input  logic [EW-1:0] rd_idx,
    output logic [31:0]   rd_data
);
    localparam int NEL = DIM * DIM;

    logic [31:0] mem [NEL];
    logic [31:0] wb_fmt;

    assign wb_fmt = d_wide ? wb_val : {16'd0, s2h(wb_val)};

    for (genvar g = 0; g < NEL; g++) begin : g_el
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[g] <= '0;
            else if (wb_en && wb_idx == EW'(g))  mem[g] <= wb_fmt;
        end
    end

    assign rd_data = mem[rd_idx];

    // R10: half-precision results land zero-extended
    p_half_zext_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !d_wide) |=> mem[$past(wb_idx)][31:16] == 16'd0);

    // R9: a NaN narrowed to half precision becomes the canonical half NaN
    p_half_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !d_wide && wb_val[30:23] == 8'hFF && wb_val[22:0] != 23'd0)
        |=> mem[$past(wb_idx)] == {16'd0, HP_QNAN});
endmodule

// File: rtl/mmac4_unit.sv
module mmac4_unit
    import mmac4_pkg::*;
#(
    parameter int DIM = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    wr_sel,
    input  logic [2*$clog2(DIM)-1:0]      wr_idx,
    input  logic [31:0]                   wr_data,
    input  logic                          c_wide,
    input  logic                          d_wide,
    input  logic                          start,
    output logic                          busy,
    output logic                          done,
    input  logic [2*$clog2(DIM)-1:0]      rd_idx,
    output logic [31:0]                   rd_data
);
    localparam int IW    = $clog2(DIM);
    localparam int EW    = 2 * IW;
    localparam int CW    = 3 * IW;
    localparam int NSTEP = DIM * DIM * DIM;
    localparam logic [CW-1:0] LAST = CW'(NSTEP - 1);

    mac_state_e  state, nxt;
    logic [CW-1:0] cnt;
    logic          cw_q, dw_q;
    logic          step_en, wb_en, first;
    logic [31:0]   acc_q, sum, c_q;
    logic [15:0]   a_q, b_q;
    logic [IW-1:0] k, row, col;
    logic [EW-1:0] elem;

    assign k    = cnt[IW-1:0];
    assign elem = cnt[CW-1:IW];
    assign row  = elem[EW-1:IW];
    assign col  = elem[IW-1:0];

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)       nxt = ST_RUN;
            ST_RUN:  if (cnt == LAST) nxt = ST_DONE;
            ST_DONE:                  nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // state register with step count and latched modes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            cw_q  <= 1'b0;
            dw_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && start) begin
                cnt  <= '0;
                cw_q <= c_wide;
                dw_q <= d_wide;
            end else if (step_en) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        done    = (state == ST_DONE);
        step_en = (state == ST_RUN);
        first   = (k == '0);
        wb_en   = step_en && (&k);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc_q <= '0;
        else if (step_en) acc_q <= sum;
    end

    mmac4_opstore #(.DIM(DIM), .EW(EW)) ops_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .a_idx({row, k}), .b_idx({k, col}), .c_idx(elem),
        .a_q(a_q), .b_q(b_q), .c_q(c_q)
    );

    mmac4_step step_i (
        .clk(clk), .rst_n(rst_n), .first(first), .c_wide(cw_q), .acc_q(acc_q),
        .c_raw(c_q), .a_op(a_q), .b_op(b_q), .sum(sum)
    );

    mmac4_rstore #(.DIM(DIM), .EW(EW)) res_i (
        .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .wb_idx(elem), .wb_val(sum),
        .d_wide(dw_q), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    // R3: done lasts one cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: done only follows the final step
    p_done_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(state) == ST_RUN && $past(cnt) == LAST));

    // R3: an idle start raises busy
    p_busy_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> busy);

    // R4: start during RUN neither restarts nor stalls the count
    p_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start && cnt != LAST) |=> (state == ST_RUN && cnt == CW'($past(cnt) + 1'b1)));

    // R11: modes hold through an operation
    p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> ($stable(cw_q) && $stable(dw_q)));
endmodule

// File: tb/mmac4_unit_tb_top.sv
`timescale 1ns/1ps
module mmac4_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [3:0]  wr_idx = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic        c_wide = 1'b0;
    logic        d_wide = 1'b0;
    logic        start = 1'b0;
    logic        busy, done;
    logic [3:0]  rd_idx = 4'd0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] ta [16];
    logic [15:0] tb [16];
    logic [31:0] tc [16];
    logic [31:0] te [16];

    // rows: pa, qa, pb, qb, pc, c_wide, d_wide
    localparam int NV = 4;
    localparam int VEC [NV][7] = '{
        '{3, 1, 5, 2, 3, 0, 0},
        '{2, 4, 3, 0, 7, 0, 1},
        '{5, 0, 2, 6, 4, 1, 0},
        '{1, 3, 4, 1, 5, 1, 1}
    };

    always #2.5 clk = ~clk;

    mmac4_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .c_wide(c_wide), .d_wide(d_wide), .start(start),
        .busy(busy), .done(done), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [15:0] int_to_h(input int v);
        int m, p;
        if (v == 0) return 16'd0;
        m = (v < 0) ? -v : v;
        p = 0;
        for (int i = 0; i < 12; i++) if (m >= (1 << i)) p = i;
        return {(v < 0), 5'(15 + p), 10'((m << (10 - p)) & 32'h3FF)};
    endfunction

    function automatic logic [31:0] int_to_s(input int v);
        int m, p;
        if (v == 0) return 32'd0;
        m = (v < 0) ? -v : v;
        p = 0;
        for (int i = 0; i < 20; i++) if (m >= (1 << i)) p = i;
        return {(v < 0), 8'(127 + p), 23'((m << (23 - p)) & 32'h7FFFFF)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 4'(idx); wr_data = val;
    endtask

    task automatic load_all();
        for (int e = 0; e < 16; e++) wr(2'd0, e, {16'd0, ta[e]});
        for (int e = 0; e < 16; e++) wr(2'd1, e, {16'd0, tb[e]});
        for (int e = 0; e < 16; e++) wr(2'd2, e, tc[e]);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R3 timing, optional R4/R11 interference
    task automatic run_op(input logic cw, input logic dw, input logic inject);
        logic early;
        early = 1'b0;
        @(negedge clk);
        start = 1'b1; c_wide = cw; d_wide = dw;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R3 busy after start", 32'(busy), 32'd1);
        for (int i = 1; i < 64; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) early = 1'b1;
            if (inject && i == 20) begin
                start = 1'b1; c_wide = ~cw; d_wide = ~dw;
            end else begin
                start = 1'b0; c_wide = cw; d_wide = dw;
            end
        end
        chk("R3 R4 no early done", 32'(early), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 done at 64th edge", 32'(done), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R3 done single cycle", 32'(done), 32'd0);
        chk("R3 idle after done", 32'(busy), 32'd0);
    endtask

    task automatic rd_chk(input int e, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_idx = 4'(e);
        #1;
        chk(tag, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R3 got=hung exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int ai [16];
        int bi [16];
        int ci [16];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 done", 32'(done), 32'd0);
        rd_chk(0, 32'd0, "R1 result 0");
        rd_chk(15, 32'd0, "R1 result 15");

        // table: exact integer matrices over all precision pairings (R2 R5 R6 R10)
        for (int v = 0; v < NV; v++) begin
            for (int e = 0; e < 16; e++) begin
                ai[e] = ((e * VEC[v][0] + VEC[v][1]) % 7) - 3;
                bi[e] = ((e * VEC[v][2] + VEC[v][3]) % 7) - 3;
                ci[e] = ((e * VEC[v][4]) % 11) - 5;
                ta[e] = int_to_h(ai[e]);
                tb[e] = int_to_h(bi[e]);
                tc[e] = (VEC[v][5] != 0) ? int_to_s(ci[e]) : {16'd0, int_to_h(ci[e])};
            end
            load_all();
            run_op(VEC[v][5] != 0, VEC[v][6] != 0, 1'b0);
            for (int e = 0; e < 16; e++) begin
                int s;
                s = ci[e];
                for (int k = 0; k < 4; k++) s += ai[(e / 4) * 4 + k] * bi[k * 4 + e % 4];
                te[e] = (VEC[v][6] != 0) ? int_to_s(s) : {16'd0, int_to_h(s)};
                rd_chk(e, te[e], "R2 R5 R6 R10 table element");
            end
        end

        // R5 ties to even in the running sum
        for (int e = 0; e < 16; e++) begin
            ta[e] = (e % 4 == 0) ? 16'h3C00 : 16'h0000;
            tb[e] = 16'h3C00;
            tc[e] = (e % 2 == 0) ? 32'h4B80_0000 : 32'h4B80_0001;
        end
        load_all();
        run_op(1'b1, 1'b1, 1'b0);
        rd_chk(0, 32'h4B80_0000, "R5 tie stays even");
        rd_chk(1, 32'h4B80_0002, "R5 tie rounds up to even");
        rd_chk(7, 32'h4B80_0002, "R5 tie rounds up to even");

        // R5 fixed order, R4 start ignored, R11 modes held
        for (int e = 0; e < 16; e++) begin
            ta[e] = 16'h3C00; tb[e] = 16'h3C00; tc[e] = 32'h4B80_0000;
        end
        load_all();
        run_op(1'b1, 1'b1, 1'b1);
        for (int e = 0; e < 16; e++)
            rd_chk(e, 32'h4B80_0000, "R5 R4 R11 ordered sum");

        // R7 narrowing, R10 zero-extension
        for (int e = 0; e < 16; e++) begin
            ta[e] = 16'h0; tb[e] = 16'h0; tc[e] = 32'h0;
        end
        tc[0] = 32'h4500_1000;  // 2049
        tc[1] = 32'h4500_3000;  // 2051
        tc[2] = 32'h477F_F000;  // 65520
        tc[3] = 32'h477F_EF00;  // 65519
        tc[4] = 32'h3800_0000;  // 2^-15
        tc[5] = 32'hB800_0000;  // -2^-15
        tc[6] = 32'hC77F_F000;  // -65520
        load_all();
        run_op(1'b1, 1'b0, 1'b0);
        rd_chk(0, 32'h0000_6800, "R7 tie to even down");
        rd_chk(1, 32'h0000_6802, "R7 tie to even up");
        rd_chk(2, 32'h0000_7C00, "R7 overflow to inf");
        rd_chk(3, 32'h0000_7BFF, "R7 round down to max");
        rd_chk(4, 32'h0000_0000, "R7 tiny to zero");
        rd_chk(5, 32'h0000_8000, "R7 tiny to negative zero");
        rd_chk(6, 32'h0000_FC00, "R7 R10 negative overflow");

        // R9 specials, R8 subnormal flush, R6 exact widening
        for (int e = 0; e < 16; e++) begin
            ta[e] = 16'h0; tb[e] = 16'h3C00; tc[e] = 32'h0;
        end
        tb[3]  = 16'h0000;
        ta[0]  = 16'h7D00;
        ta[4]  = 16'h7C00;
        ta[8]  = 16'h7C00; ta[9] = 16'hFC00;
        ta[12] = 16'h0001; ta[13] = 16'h03FF;
        tc[12] = 32'h0000_3C00;
        tc[13] = 32'h0000_3555;
        tc[14] = 32'h0000_8200;
        tc[15] = 32'h0000_0200;
        load_all();
        run_op(1'b0, 1'b1, 1'b0);
        rd_chk(0, 32'h7FC0_0000, "R9 NaN operand");
        rd_chk(3, 32'h7FC0_0000, "R9 NaN times zero");
        rd_chk(5, 32'h7F80_0000, "R9 inf propagates");
        rd_chk(7, 32'h7FC0_0000, "R9 inf times zero");
        rd_chk(9, 32'h7FC0_0000, "R9 opposite infinities");
        rd_chk(12, 32'h3F80_0000, "R8 subnormal inputs flushed");
        rd_chk(13, 32'h3EAA_A000, "R6 exact widening");
        rd_chk(14, 32'h0000_0000, "R8 negative subnormal C flushed");
        rd_chk(15, 32'h0000_0000, "R8 subnormal C flushed");

        // R10 results held while idle
        repeat (10) @(negedge clk);
        rd_chk(13, 32'h3EAA_A000, "R10 held while idle");
        rd_chk(5, 32'h7F80_0000, "R10 held while idle");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule